// File: doc/BRIEF.md
# Cipher Command Controller

This block is the processor-side command logic of a block-cipher coprocessor. A host reaches it through a small register window: three address lines, a read/write line, a chip select and a one-cycle access enable, with the byte bus split into a write path (`wdata`) and a read path (`rdata` with its own output enable). From the address and the direction it decodes eleven operations. It gathers an eight-byte block in a 64-bit data register, starts a job when the last byte lands on one of the trigger addresses, tracks the busy period and drives two interrupt lines. Once a job is done, it serves the result a byte at a time and wipes each byte as it goes out.

The cipher datapath and the key storage sit outside. The datapath is modelled by a latency counter in a separate processing-clock domain. Its run request and its completion cross between the domains as a four-phase level handshake through two-flop synchronizers. The job code and the assembled block are presented on `op_code` and `op_block`, and the result comes back on `op_result` at completion. Key bytes go out on a write strobe to the key store.

The controller has four states. IDLE moves to RUN on a trigger write while the byte count is 7, or on a transfer read. RUN moves to CLOSE once the synchronized completion is seen. CLOSE moves to RESULT (data jobs) or back to IDLE (key and transfer jobs) once the completion level has dropped again. RESULT returns to IDLE on the eighth data read or on a staging write, and moves to RUN on a transfer read. A software reset moves any state to IDLE.

Top module: `cipher_cmd_ctrl`

## Requirements
- R1: Operation decode. Reads: address 0 is status, 1 is data out, 2 is major-key transfer, and 3 to 7 return zero with no effect. Writes: address 0 is software reset, 1 is staging byte, 2 is encipher data, 3 is decipher data, 4 is encipher key, 5 is decipher key, 6 is a major key byte, 7 is a plain secondary key byte.
- R2: A staging write in IDLE shifts its byte into the low end of the data register, so the first byte ends up most significant. It also increments the byte count, which is shown in status bits 2:0 and wraps to 0 after eight writes.
- R3: A trigger write (addresses 2 to 5) while the count is 7 shifts in the eighth byte, clears the count and starts the job (op_code 0 encipher data, 1 decipher data, 2 encipher key, 3 decipher key). A trigger write at any other count has no effect.
- R4: A job lasts its own latency in processing-clock cycles: LAT_DATA for data jobs, LAT_KEY for key jobs and LAT_XFER for the transfer (op_code 4). The busy period seen on the bus is that latency plus a bounded synchronizer overhead of 2 to 20 bus cycles.
- R5: Status bit 7 and irq_busy are high from the cycle after a start until the job has closed. irq_result is never high at the same time.
- R6: While busy, every command except a status read and a software reset is ignored. In particular, staging writes do not move the count, and key writes produce no key strobe.
- R7: A data read outside RESULT returns zero and changes nothing.
- R8: After a data job, status bit 6 and irq_result are high. Eight data reads return op_result most significant byte first, each read shifting zeros in. irq_result then falls, and further reads return zero.
- R9: A software reset at any time, including mid-job, clears the state, the count, the data register and both flags. An aborted job never completes later.
- R10: A hardware reset clears the state, the count, the data register and both interrupt outputs, and the status read returns zero afterwards.
- R11: A key write outside the busy period pulses key_we with the byte on key_byte, and with key_sel at 0 for address 6 and 1 for address 7.
- R12: During RUN, op_block holds the assembled block and op_code holds the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| proc_clk | input | 1 | Processing clock for the latency model |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| en | input | 1 | One-cycle access enable |
| cs | input | 1 | Chip select |
| rw | input | 1 | 1 read, 0 write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the access cycle |
| rdata_oe | output | 1 | Read bus drive enable |
| irq_busy | output | 1 | High while a job runs |
| irq_result | output | 1 | High while result bytes are waiting |
| op_code | output | 3 | Current job code |
| op_block | output | 64 | Block handed to the datapath |
| op_result | input | 64 | Datapath result, taken at completion |
| key_we | output | 1 | Key byte write strobe |
| key_sel | output | 1 | 0 major key, 1 secondary key |
| key_byte | output | 8 | Key byte |

## Verification
The bench builds the block with LAT_DATA=12, LAT_KEY=40 and LAT_XFER=4, so each busy window is only a few dozen cycles long. That lets a sweep of blocks over all four trigger addresses, plus transfer and abort cases, fit in a short run. The wide gap between 12 and 40 means the measured busy length tells the data latency from the key latency, and the short transfer latency exercises the handshake at its tightest. Block bytes and expected results are computed arithmetically from the block index.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_STATUS,
        OP_RDDATA,
        OP_XFER,
        OP_SRST,
        OP_STAGE,
        OP_ENC_D,
        OP_DEC_D,
        OP_ENC_K,
        OP_DEC_K,
        OP_KEY_MAJ,
        OP_KEY_SEC
    } bus_op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_CLOSE,
        ST_RESULT
    } ctl_state_t;

    typedef enum logic [2:0] {
        JOB_ENC_DATA = 3'd0,
        JOB_DEC_DATA = 3'd1,
        JOB_ENC_KEY  = 3'd2,
        JOB_DEC_KEY  = 3'd3,
        JOB_XFER     = 3'd4
    } job_t;

endpackage

// File: rtl/cc_decode.sv
`timescale 1ns/1ps
module cc_decode
    import cc_pkg::*;
(
    input  logic       acc,
    input  logic       rw,
    input  logic [2:0] addr,
    output bus_op_t    op
);
    always_comb begin
        op = OP_NONE;
        if (acc) begin
            if (rw) begin
                unique case (addr)
                    3'd0:    op = OP_STATUS;
                    3'd1:    op = OP_RDDATA;
                    3'd2:    op = OP_XFER;
                    default: op = OP_NONE;
                endcase
            end else begin
                unique case (addr)
                    3'd0: op = OP_SRST;
                    3'd1: op = OP_STAGE;
                    3'd2: op = OP_ENC_D;
                    3'd3: op = OP_DEC_D;
                    3'd4: op = OP_ENC_K;
                    3'd5: op = OP_DEC_K;
                    3'd6: op = OP_KEY_MAJ;
                    3'd7: op = OP_KEY_SEC;
                endcase
            end
        end
    end
endmodule

// File: rtl/cc_sync2.sv
`timescale 1ns/1ps
module cc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cc_latency.sv
`timescale 1ns/1ps
module cc_latency
    import cc_pkg::*;
#(
    parameter int LAT_DATA = 320,
    parameter int LAT_KEY  = 328,
    parameter int LAT_XFER = 8
) (
    input  logic proc_clk,
    input  logic rst_n,
    input  logic run_req,
    input  job_t job,
    output logic done
);
    localparam int LMAX1 = (LAT_DATA > LAT_KEY) ? LAT_DATA : LAT_KEY;
    localparam int LMAX  = (LMAX1 > LAT_XFER) ? LMAX1 : LAT_XFER;
    localparam int LCW   = $clog2(LMAX + 1);

    logic           run_s;
    logic [LCW-1:0] cnt_q;
    logic [LCW-1:0] lim;
    logic [LCW-1:0] lim_m1;
    logic           done_q;

    cc_sync2 #(.STAGES(2)) u_run_sync (
        .clk   (proc_clk),
        .rst_n (rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    always_comb begin
        unique case (job)
            JOB_ENC_DATA, JOB_DEC_DATA: lim = LCW'(LAT_DATA);
            JOB_ENC_KEY,  JOB_DEC_KEY:  lim = LCW'(LAT_KEY);
            default:                    lim = LCW'(LAT_XFER);
        endcase
        lim_m1 = lim - LCW'(1);
    end

    always_ff @(posedge proc_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!run_s) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == lim_m1) done_q <= 1'b1;
            else                 cnt_q  <= cnt_q + LCW'(1);
        end
    end

    assign done = done_q;
endmodule

// File: rtl/cipher_cmd_ctrl.sv
`timescale 1ns/1ps
module cipher_cmd_ctrl
    import cc_pkg::*;
#(
    parameter int BYTES    = 8,
    parameter int LAT_DATA = 320,
    parameter int LAT_KEY  = 328,
    parameter int LAT_XFER = 8
) (
    input  logic              clk,
    input  logic              proc_clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cs,
    input  logic              rw,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              irq_busy,
    output logic              irq_result,
    output logic [2:0]        op_code,
    output logic [BYTES*8-1:0] op_block,
    input  logic [BYTES*8-1:0] op_result,
    output logic              key_we,
    output logic              key_sel,
    output logic [7:0]        key_byte
);
    localparam int DW   = BYTES * 8;
    localparam int CNTW = $clog2(BYTES);
    localparam int PADW = 8 - 2 - CNTW;
    localparam logic [CNTW-1:0] LAST = CNTW'(BYTES - 1);

    bus_op_t         op;
    ctl_state_t      st_q, st_d;
    logic [DW-1:0]   data_q, data_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    job_t            job_q, job_d;
    logic            done_p, done_b;
    logic            busy, res_rdy, data_job;
    logic [7:0]      status;

    cc_decode u_dec (
        .acc  (en & cs),
        .rw   (rw),
        .addr (addr),
        .op   (op)
    );

    cc_latency #(
        .LAT_DATA (LAT_DATA),
        .LAT_KEY  (LAT_KEY),
        .LAT_XFER (LAT_XFER)
    ) u_lat (
        .proc_clk (proc_clk),
        .rst_n    (rst_n),
        .run_req  (st_q == ST_RUN),
        .job      (job_q),
        .done     (done_p)
    );

    cc_sync2 #(.STAGES(2)) u_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (done_p),
        .q     (done_b)
    );

    assign busy     = (st_q == ST_RUN) || (st_q == ST_CLOSE);
    assign res_rdy  = (st_q == ST_RESULT);
    assign data_job = (job_q == JOB_ENC_DATA) || (job_q == JOB_DEC_DATA);
    assign status   = {busy, res_rdy, {PADW{1'b0}}, cnt_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
            cnt_q  <= '0;
            job_q  <= JOB_ENC_DATA;
        end else begin
            st_q   <= st_d;
            data_q <= data_d;
            cnt_q  <= cnt_d;
            job_q  <= job_d;
        end
    end

    // next state and datapath updates
    always_comb begin
        st_d   = st_q;
        data_d = data_q;
        cnt_d  = cnt_q;
        job_d  = job_q;
        if (op == OP_SRST) begin
            st_d   = ST_IDLE;
            data_d = '0;
            cnt_d  = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    unique case (op)
                        OP_STAGE: begin
                            data_d = {data_q[DW-9:0], wdata};
                            cnt_d  = cnt_q + CNTW'(1);
                        end
                        OP_ENC_D, OP_DEC_D, OP_ENC_K, OP_DEC_K: begin
                            if (cnt_q == LAST) begin
                                data_d = {data_q[DW-9:0], wdata};
                                cnt_d  = '0;
                                st_d   = ST_RUN;
                                unique case (op)
                                    OP_ENC_D: job_d = JOB_ENC_DATA;
                                    OP_DEC_D: job_d = JOB_DEC_DATA;
                                    OP_ENC_K: job_d = JOB_ENC_KEY;
                                    default:  job_d = JOB_DEC_KEY;
                                endcase
                            end
                        end
                        OP_XFER: begin
                            cnt_d = '0;
                            job_d = JOB_XFER;
                            st_d  = ST_RUN;
                        end
                        default: ;
                    endcase
                end
                ST_RUN: begin
                    if (done_b) begin
                        data_d = data_job ? op_result : '0;
                        st_d   = ST_CLOSE;
                    end
                end
                ST_CLOSE: begin
                    if (!done_b) st_d = data_job ? ST_RESULT : ST_IDLE;
                end
                ST_RESULT: begin
                    unique case (op)
                        OP_RDDATA: begin
                            data_d = {data_q[DW-9:0], 8'h00};
                            cnt_d  = cnt_q + CNTW'(1);
                            if (cnt_q == LAST) st_d = ST_IDLE;
                        end
                        OP_STAGE: begin
                            data_d = {{(DW-8){1'b0}}, wdata};
                            cnt_d  = CNTW'(1);
                            st_d   = ST_IDLE;
                        end
                        OP_XFER: begin
                            data_d = '0;
                            cnt_d  = '0;
                            job_d  = JOB_XFER;
                            st_d   = ST_RUN;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        rdata = 8'h00;
        if (op == OP_STATUS)                          rdata = status;
        else if (op == OP_RDDATA && st_q == ST_RESULT) rdata = data_q[DW-1 -: 8];
        rdata_oe   = en & cs & rw;
        irq_busy   = busy;
        irq_result = res_rdy;
        op_code    = job_q;
        op_block   = data_q;
        key_we     = (op == OP_KEY_MAJ || op == OP_KEY_SEC) && !busy;
        key_sel    = (op == OP_KEY_SEC);
        key_byte   = wdata;
    end

    // R2
    stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && op == OP_STAGE) |=>
            (data_q[7:0] == $past(wdata) && cnt_q == CNTW'($past(cnt_q) + CNTW'(1))));

    // R6
    cnt_frozen_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q == '0));

    // R12
    block_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> ($stable(data_q) && $stable(job_q)));

    // R7
    early_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RDDATA && st_q != ST_RESULT) |-> (rdata == 8'h00));

    // R8
    read_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESULT && op == OP_RDDATA) |=> (data_q[7:0] == 8'h00));

    // R5
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_busy |-> !irq_result);

    // R11
    key_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_we |-> !irq_busy);
endmodule

// File: tb/cipher_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module cipher_cmd_ctrl_tb;
    localparam int LD = 12;
    localparam int LK = 40;
    localparam int LX = 4;
    localparam logic [63:0] MASK = 64'hA5A5_5A5A_0F0F_F0F0;

    logic        clk = 1'b0;
    logic        proc_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, cs = 1'b0, rw = 1'b1;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        rdata_oe, irq_busy, irq_result, key_we, key_sel;
    logic [2:0]  op_code;
    logic [63:0] op_block, op_result;
    logic [7:0]  key_byte;

    int checks = 0;
    int fails  = 0;
    int ncyc   = 0;
    logic [7:0] last_rd;
    logic       last_kwe, last_ksel;
    logic [7:0] last_kb;

    always #2.5 clk = ~clk;
    initial begin
        #1.3;
        forever #2.5 proc_clk = ~proc_clk;
    end

    // stand-in datapath result
    assign op_result = (op_code == 3'd0) ? (op_block ^ MASK) :
                       (op_code == 3'd1) ? {op_block[31:0], op_block[63:32]} : '1;

    cipher_cmd_ctrl #(.BYTES(8), .LAT_DATA(LD), .LAT_KEY(LK), .LAT_XFER(LX)) u_dut (
        .clk(clk), .proc_clk(proc_clk), .rst_n(rst_n), .en(en), .cs(cs), .rw(rw),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .irq_busy(irq_busy), .irq_result(irq_result), .op_code(op_code),
        .op_block(op_block), .op_result(op_result), .key_we(key_we),
        .key_sel(key_sel), .key_byte(key_byte)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic r, input logic [2:0] a, input logic [7:0] d);
        en = 1'b1; cs = 1'b1; rw = r; addr = a; wdata = d;
        @(negedge clk);
        last_rd = rdata; last_kwe = key_we; last_ksel = key_sel; last_kb = key_byte;
        @(posedge clk); #1;
        en = 1'b0; cs = 1'b0; rw = 1'b1;
        ncyc++;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d); acc(1'b0, a, d); endtask
    task automatic rd(input logic [2:0] a); acc(1'b1, a, 8'h00); endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ncyc++;
        end
    endtask

    task automatic wait_idle(input int n0, output int d);
        int guard;
        guard = 0;
        do begin
            rd(3'd0);
            guard++;
        end while (last_rd[7] && guard < 1000);
        d = ncyc - n0;
    endtask

    task automatic run_block(input int blk, input int job, input bit mid);
        logic [7:0]  b;
        logic [63:0] e, x;
        int n0, d, lat;
        e = '0;
        b = 8'h00;
        for (int k = 0; k < 8; k++) begin
            b = 8'((blk * 37 + k * 11 + 3) & 255);
            e = {e[55:0], b};
            if (k < 7) wr(3'd1, b);
        end
        rd(3'd0);
        chk(last_rd == 8'h07, "R2 count before trigger", 64'(last_rd), 64'h07);
        wr(3'(2 + job), b);
        n0 = ncyc;
        rd(3'd0);
        chk(last_rd == 8'h80, "R5 status busy", 64'(last_rd), 64'h80);
        chk(irq_busy && !irq_result, "R5 irq lines", {62'b0, irq_busy, irq_result}, 64'h2);
        chk(op_block == e, "R12 op_block", op_block, e);
        chk(op_code == 3'(job), "R12 op_code", 64'(op_code), 64'(job));
        if (mid) begin
            rd(3'd1);
            chk(last_rd == 8'h00, "R7 early read", 64'(last_rd), 64'h0);
            wr(3'd1, 8'h55);
            wr(3'd6, 8'h11);
            chk(!last_kwe, "R6 key strobe while busy", 64'(last_kwe), 64'h0);
            wr(3'd2, 8'h22);
            rd(3'd0);
            chk(last_rd == 8'h80, "R6 count frozen", 64'(last_rd), 64'h80);
            chk(op_block == e, "R6 block untouched", op_block, e);
        end
        wait_idle(n0, d);
        lat = (job < 2) ? LD : LK;
        chk(d >= lat + 2 && d <= lat + 20, "R4 busy length", 64'(d), 64'(lat));
        if (job < 2) begin
            x = (job == 0) ? (e ^ MASK) : {e[31:0], e[63:32]};
            chk(last_rd == 8'h40 && irq_result, "R8 result ready", 64'(last_rd), 64'h40);
            for (int k = 0; k < 8; k++) begin
                rd(3'd1);
                chk(last_rd == 8'(x >> (56 - 8 * k)), "R8 readout byte", 64'(last_rd), 64'(8'(x >> (56 - 8 * k))));
            end
            chk(!irq_result, "R8 irq_result after drain", 64'(irq_result), 64'h0);
            rd(3'd1);
            chk(last_rd == 8'h00, "R8 read after drain", 64'(last_rd), 64'h0);
        end else begin
            chk(last_rd == 8'h00 && !irq_result, "R4 key job leaves no result", 64'(last_rd), 64'h0);
            rd(3'd1);
            chk(last_rd == 8'h00, "R7 no data after key job", 64'(last_rd), 64'h0);
        end
    endtask

    initial begin
        #750000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d, n0;
        repeat (4) @(posedge clk);
        #1;
        chk(!irq_busy && !irq_result, "R10 irq in reset", {62'b0, irq_busy, irq_result}, 64'h0);
        rst_n = 1'b1;
        idle(3);
        rd(3'd0);
        chk(last_rd == 8'h00, "R10 status after reset", 64'(last_rd), 64'h0);

        // R11 key writes
        wr(3'd6, 8'h3C);
        chk(last_kwe && !last_ksel && last_kb == 8'h3C, "R11 major key byte",
            {55'b0, last_kwe, last_ksel, last_kb}, {55'b0, 1'b1, 1'b0, 8'h3C});
        wr(3'd7, 8'hC3);
        chk(last_kwe && last_ksel && last_kb == 8'hC3, "R11 secondary key byte",
            {55'b0, last_kwe, last_ksel, last_kb}, {55'b0, 1'b1, 1'b1, 8'hC3});

        // R1 unused read addresses
        for (int a = 3; a < 8; a++) begin
            rd(3'(a));
            chk(last_rd == 8'h00, "R1 unused read", 64'(last_rd), 64'h0);
        end
        rd(3'd0);
        chk(last_rd == 8'h00, "R1 unused reads left state", 64'(last_rd), 64'h0);

        // R2 count wrap, R3 trigger at wrong count
        for (int k = 0; k < 8; k++) begin
            wr(3'd1, 8'(k));
            rd(3'd0);
            chk(last_rd == 8'((k + 1) % 8), "R2 count step", 64'(last_rd), 64'((k + 1) % 8));
        end
        for (int a = 2; a < 6; a++) begin
            wr(3'(a), 8'hEE);
            rd(3'd0);
            chk(last_rd == 8'h00, "R3 trigger at count 0 ignored", 64'(last_rd), 64'h0);
        end

        // main sweep over trigger addresses
        for (int blk = 0; blk < 8; blk++) run_block(blk, blk % 4, blk == 2);

        // transfer
        rd(3'd2);
        n0 = ncyc;
        chk(irq_busy && op_code == 3'd4, "R1 transfer read starts job", {60'b0, irq_busy, op_code}, 64'hC);
        wait_idle(n0, d);
        chk(d >= LX + 2 && d <= LX + 20, "R4 transfer busy length", 64'(d), 64'(LX));
        chk(last_rd == 8'h00, "R4 transfer leaves no result", 64'(last_rd), 64'h0);

        // R9 software reset mid-job
        for (int k = 0; k < 7; k++) wr(3'd1, 8'(k + 100));
        wr(3'd2, 8'h77);
        idle(3);
        wr(3'd0, 8'h00);
        rd(3'd0);
        chk(last_rd == 8'h00 && !irq_busy, "R9 abort clears status", 64'(last_rd), 64'h0);
        idle(40);
        rd(3'd0);
        chk(last_rd == 8'h00 && !irq_result, "R9 aborted job never completes", 64'(last_rd), 64'h0);
        rd(3'd1);
        chk(last_rd == 8'h00, "R9 data cleared", 64'(last_rd), 64'h0);
        for (int k = 0; k < 3; k++) wr(3'd1, 8'h10);
        wr(3'd0, 8'h00);
        rd(3'd0);
        chk(last_rd == 8'h00, "R9 count cleared", 64'(last_rd), 64'h0);
        run_block(9, 0, 1'b0);

        // R10 hardware reset mid-job
        for (int k = 0; k < 7; k++) wr(3'd1, 8'(k));
        wr(3'd3, 8'h99);
        idle(4);
        rst_n = 1'b0;
        idle(2);
        chk(!irq_busy && !irq_result && op_block == 64'h0, "R10 reset mid-job", op_block, 64'h0);
        rst_n = 1'b1;
        idle(40);
        rd(3'd0);
        chk(last_rd == 8'h00, "R10 status after mid-job reset", 64'(last_rd), 64'h0);
        run_block(11, 1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule